// File: doc/BRIEF.md
# Memory Controller Configuration Register File

This block holds the configuration and status state of an external-memory controller. Software reaches it through two ports on a simple register bus. A write to the index port selects a register. An access to the data port then reads or writes the selected register. The file holds the following registers:

- two write-one-to-clear error words and an error address;
- a global control word and a read-only status word;
- refresh and power-management timing;
- up to four bank descriptors;
- an ECC configuration word and an ECC error word.

Each bank descriptor decodes into a base address, a power-of-two size and an enable. A combinational probe decoder compares a physical address against every active bank. It returns a one-hot bank select and a hit flag. A registered interrupt is raised while the ECC error word is nonzero. Command sequencing and the memory data path belong to other blocks.

Top module: `memctl_cfg_regs`

## Requirements
- R1: A write with `bus_port`=0 loads the full 32-bit index. With `bus_port`=0, `bus_rdata` returns the index. With `bus_port`=1, a write goes to the register the index selects, and `bus_rdata` shows that register.
- R2: After reset the registers read as follows: index 0, control 0x00800000, refresh 0x05F00000, power-management 0x07C00000. Status, both error words, the error address, ECC configuration, ECC error and every bank descriptor read 0. No bank hits and `ecc_irq` is low.
- R3: Control (index 0x20) stores the written value ANDed with 0xFFE00000.
  - When control bit 31 goes from 0 to 1, status (index 0x24) bit 31 clears. When it goes from 1 to 0, status bit 31 sets.
  - When control bit 30 rises, status bit 30 sets. When it falls, status bit 30 clears.
  - Writes to the status index change nothing.
- R4: Refresh (0x30) stores data AND 0x3FF80000. Power-management (0x34) stores (data AND 0xF8000000) OR 0x07C00000. ECC configuration (0x94) stores data AND 0x00F00000. The error address (0x10) stores all 32 bits.
- R5: The error words at 0x00 and 0x08 clear the bits written as one. No write sets any of their bits.
- R6: Bank n is at index 0x40+4n and stores data AND 0xFFDEE001. The base is bits 31:23 with the low bits zero. The size is 4 MiB shifted left by the code in bits 19:17. Bit 0 is the bank enable.
- R7: Bank n drives `probe_sel` bit n and `probe_hit` only when all of the following hold:
  - its enable bit is set;
  - control bit 31 is set;
  - its size code is not 7;
  - `probe_addr` AND NOT(size-1) equals its base.
- R8: If several banks match, only the lowest-numbered bank's bit is set in `probe_sel`.
- R9: The ECC error word (0x98) stores data AND 0xFFF0F000. `ecc_irq` is high from the clock edge of a write that leaves the word nonzero. It is low from the edge of a write that leaves it zero.
- R10: Reading the timing index 0x80, any unlisted index, or a bank index beyond the configured bank count returns 0xFFFFFFFF. Writes to such indices change no register.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| bus_wr | input | 1 | Write strobe for the selected port |
| bus_port | input | 1 | 0 selects the index port, 1 the data port |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data for the selected port (combinational) |
| probe_addr | input | 32 | Physical address to decode |
| probe_hit | output | 1 | Some active bank contains `probe_addr` |
| probe_sel | output | NUM_BANKS | One-hot select of the winning bank |
| ecc_irq | output | 1 | ECC error interrupt, registered |

## Verification
A corrupted index register misdirects the very next data-port access. It is seen on the first readback after the index write, so the bench reads back after every write. A wrong bank descriptor or control enable bit shows on `probe_sel` in the same cycle as the probe. Random probe addresses are therefore aimed at programmed bases to reach both hits and near misses. A status bit that tracks control edges in the wrong direction shows only after a control toggle. For that reason the control enable is toggled in both directions, and status is read after each change.

// File: rtl/memctl_cfg_pkg.sv
package memctl_cfg_pkg;
   typedef logic [31:0] word_t;

   // register indices on the data port
   localparam word_t IX_ERR0   = 32'h00;
   localparam word_t IX_ERR1   = 32'h08;
   localparam word_t IX_EADDR  = 32'h10;
   localparam word_t IX_CTL    = 32'h20;
   localparam word_t IX_STAT   = 32'h24;
   localparam word_t IX_REFR   = 32'h30;
   localparam word_t IX_PWR    = 32'h34;
   localparam word_t IX_BANK0  = 32'h40;
   localparam word_t IX_TIMING = 32'h80;
   localparam word_t IX_ECFG   = 32'h94;
   localparam word_t IX_EERR   = 32'h98;

   // write masks and forced bits
   localparam word_t M_CTL      = 32'hFFE0_0000;
   localparam word_t M_REFR     = 32'h3FF8_0000;
   localparam word_t M_PWR_KEEP = 32'hF800_0000;
   localparam word_t M_PWR_SET  = 32'h07C0_0000;
   localparam word_t M_BANK     = 32'hFFDE_E001;
   localparam word_t M_ECFG     = 32'h00F0_0000;
   localparam word_t M_EERR     = 32'hFFF0_F000;

   // reset values
   localparam word_t RV_CTL  = 32'h0080_0000;
   localparam word_t RV_REFR = 32'h05F0_0000;
   localparam word_t RV_PWR  = 32'h07C0_0000;

   // field positions
   localparam int CTL_EN_BIT = 31;
   localparam int CTL_SR_BIT = 30;
   localparam int BASE_LSB   = 23;
   localparam int SZ_LSB     = 17;
   localparam int SZ_W       = 3;
   localparam int MAX_BANKS  = 4;
endpackage

// File: rtl/memctl_cfg_bank.sv
module memctl_cfg_bank
   import memctl_cfg_pkg::*;
#(
   parameter int SIZE_UNIT_LOG2 = 22
)(
   input  logic  clk,
   input  logic  rst_n,
   input  logic  wr_en,
   input  word_t wdata,
   input  logic  ctl_en,
   input  word_t probe_addr,
   output word_t reg_q,
   output logic  match
);
   localparam int SZ_RESERVED = (1 << SZ_W) - 1;

   logic [SZ_W-1:0] code;
   word_t           base;
   word_t           size_mask;
   logic            code_ok;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)     reg_q <= '0;
      else if (wr_en) reg_q <= wdata & M_BANK;
   end

   assign code    = reg_q[SZ_LSB +: SZ_W];
   assign base    = {reg_q[31:BASE_LSB], {BASE_LSB{1'b0}}};
   assign code_ok = (int'(code) != SZ_RESERVED);

   always_comb begin
      size_mask = ~((word_t'(1) << (SIZE_UNIT_LOG2 + int'(code))) - word_t'(1));
   end

   assign match = ctl_en & reg_q[0] & code_ok & ((probe_addr & size_mask) == base);
endmodule

// File: rtl/memctl_cfg_prio.sv
module memctl_cfg_prio #(
   parameter int N = 4
)(
   input  logic [N-1:0] req,
   output logic [N-1:0] gnt,
   output logic         any
);
   logic [N:0] seen;

   assign seen[0] = 1'b0;
   for (genvar i = 0; i < N; i++) begin : g_chain
      assign gnt[i]    = req[i] & ~seen[i];
      assign seen[i+1] = seen[i] | req[i];
   end
   assign any = seen[N];
endmodule

// File: rtl/memctl_cfg_ecc.sv
module memctl_cfg_ecc
   import memctl_cfg_pkg::*;
(
   input  logic  clk,
   input  logic  rst_n,
   input  logic  wr_en,
   input  word_t wdata,
   output word_t err_q,
   output logic  irq
);
   word_t nxt;

   assign nxt = wdata & M_EERR;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         err_q <= '0;
         irq   <= 1'b0;
      end else if (wr_en) begin
         err_q <= nxt;
         irq   <= |nxt;
      end
   end
endmodule

// File: rtl/memctl_cfg_regs.sv
module memctl_cfg_regs
   import memctl_cfg_pkg::*;
#(
   parameter int NUM_BANKS      = 4,
   parameter int SIZE_UNIT_LOG2 = 22
)(
   input  logic                 clk,
   input  logic                 rst_n,
   input  logic                 bus_wr,
   input  logic                 bus_port,
   input  logic [31:0]          bus_wdata,
   output logic [31:0]          bus_rdata,
   input  logic [31:0]          probe_addr,
   output logic                 probe_hit,
   output logic [NUM_BANKS-1:0] probe_sel,
   output logic                 ecc_irq
);
   localparam int MAX_SHIFT = SIZE_UNIT_LOG2 + (1 << SZ_W) - 2;

   if (NUM_BANKS < 1 || NUM_BANKS > MAX_BANKS) begin : g_bad_banks
      $error("NUM_BANKS out of range");
   end
   if (SIZE_UNIT_LOG2 < 1 || MAX_SHIFT > 31) begin : g_bad_unit
      $error("SIZE_UNIT_LOG2 out of range");
   end

   word_t idx_q, ctl_q, stat_q, err0_q, err1_q, eaddr_q, refr_q, pwr_q, ecfg_q, eerr_q;
   word_t bank_q [NUM_BANKS];
   logic [NUM_BANKS-1:0] bank_match;
   word_t ctl_nxt, rd_reg;
   logic  wr_idx, wr_data;
   logic  wr_err0, wr_err1, wr_eaddr, wr_ctl, wr_refr, wr_pwr, wr_ecfg, wr_eerr;

   assign wr_idx   = bus_wr & ~bus_port;
   assign wr_data  = bus_wr & bus_port;
   assign wr_err0  = wr_data & (idx_q == IX_ERR0);
   assign wr_err1  = wr_data & (idx_q == IX_ERR1);
   assign wr_eaddr = wr_data & (idx_q == IX_EADDR);
   assign wr_ctl   = wr_data & (idx_q == IX_CTL);
   assign wr_refr  = wr_data & (idx_q == IX_REFR);
   assign wr_pwr   = wr_data & (idx_q == IX_PWR);
   assign wr_ecfg  = wr_data & (idx_q == IX_ECFG);
   assign wr_eerr  = wr_data & (idx_q == IX_EERR);
   assign ctl_nxt  = bus_wdata & M_CTL;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)      idx_q <= '0;
      else if (wr_idx) idx_q <= bus_wdata;
   end

   // control word and the status bits that follow its edges
   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         ctl_q  <= RV_CTL;
         stat_q <= '0;
      end else if (wr_ctl) begin
         ctl_q <= ctl_nxt;
         if (!ctl_q[CTL_EN_BIT] && ctl_nxt[CTL_EN_BIT])      stat_q[CTL_EN_BIT] <= 1'b0;
         else if (ctl_q[CTL_EN_BIT] && !ctl_nxt[CTL_EN_BIT]) stat_q[CTL_EN_BIT] <= 1'b1;
         if (!ctl_q[CTL_SR_BIT] && ctl_nxt[CTL_SR_BIT])      stat_q[CTL_SR_BIT] <= 1'b1;
         else if (ctl_q[CTL_SR_BIT] && !ctl_nxt[CTL_SR_BIT]) stat_q[CTL_SR_BIT] <= 1'b0;
      end
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         err0_q  <= '0;
         err1_q  <= '0;
         eaddr_q <= '0;
         refr_q  <= RV_REFR;
         pwr_q   <= RV_PWR;
         ecfg_q  <= '0;
      end else begin
         if (wr_err0)  err0_q  <= err0_q & ~bus_wdata;
         if (wr_err1)  err1_q  <= err1_q & ~bus_wdata;
         if (wr_eaddr) eaddr_q <= bus_wdata;
         if (wr_refr)  refr_q  <= bus_wdata & M_REFR;
         if (wr_pwr)   pwr_q   <= (bus_wdata & M_PWR_KEEP) | M_PWR_SET;
         if (wr_ecfg)  ecfg_q  <= bus_wdata & M_ECFG;
      end
   end

   for (genvar b = 0; b < NUM_BANKS; b++) begin : g_bank
      logic wr_b;
      assign wr_b = wr_data & (idx_q == IX_BANK0 + word_t'(4 * b));
      memctl_cfg_bank #(.SIZE_UNIT_LOG2(SIZE_UNIT_LOG2)) u_bank (
         .clk        (clk),
         .rst_n      (rst_n),
         .wr_en      (wr_b),
         .wdata      (bus_wdata),
         .ctl_en     (ctl_q[CTL_EN_BIT]),
         .probe_addr (probe_addr),
         .reg_q      (bank_q[b]),
         .match      (bank_match[b])
      );
   end

   memctl_cfg_prio #(.N(NUM_BANKS)) u_prio (
      .req (bank_match),
      .gnt (probe_sel),
      .any (probe_hit)
   );

   memctl_cfg_ecc u_ecc (
      .clk   (clk),
      .rst_n (rst_n),
      .wr_en (wr_eerr),
      .wdata (bus_wdata),
      .err_q (eerr_q),
      .irq   (ecc_irq)
   );

   always_comb begin
      case (idx_q)
         IX_ERR0:   rd_reg = err0_q;
         IX_ERR1:   rd_reg = err1_q;
         IX_EADDR:  rd_reg = eaddr_q;
         IX_CTL:    rd_reg = ctl_q;
         IX_STAT:   rd_reg = stat_q;
         IX_REFR:   rd_reg = refr_q;
         IX_PWR:    rd_reg = pwr_q;
         IX_TIMING: rd_reg = '1;
         IX_ECFG:   rd_reg = ecfg_q;
         IX_EERR:   rd_reg = eerr_q;
         default:   rd_reg = '1;
      endcase
      for (int b = 0; b < NUM_BANKS; b++) begin
         if (idx_q == IX_BANK0 + word_t'(4 * b)) rd_reg = bank_q[b];
      end
      bus_rdata = bus_port ? rd_reg : idx_q;
   end
endmodule

// File: rtl/memctl_cfg_regs_chk.sv
module memctl_cfg_regs_chk
   import memctl_cfg_pkg::*;
#(
   parameter int NUM_BANKS = 4
)(
   input logic                 clk,
   input logic                 rst_n,
   input logic                 bus_wr,
   input logic                 bus_port,
   input word_t                bus_wdata,
   input word_t                idx_q,
   input word_t                ctl_q,
   input word_t                stat_q,
   input word_t                pwr_q,
   input logic                 probe_hit,
   input logic [NUM_BANKS-1:0] probe_sel,
   input logic                 ecc_irq
);
   AST_SEL_ONEHOT: assert property (@(posedge clk) disable iff (!rst_n)
      $onehot0(probe_sel)); // R8
   AST_HIT_AGREES: assert property (@(posedge clk) disable iff (!rst_n)
      probe_hit == (probe_sel != '0)); // R7
   AST_CTL_OFF_NO_HIT: assert property (@(posedge clk) disable iff (!rst_n)
      !ctl_q[CTL_EN_BIT] |-> !probe_hit); // R7
   AST_IDX_LOAD: assert property (@(posedge clk) disable iff (!rst_n)
      (bus_wr && !bus_port) |=> idx_q == $past(bus_wdata)); // R1
   AST_CTL_MASKED: assert property (@(posedge clk) disable iff (!rst_n)
      (ctl_q & ~M_CTL) == '0); // R3
   AST_STAT_EN_CLEAR: assert property (@(posedge clk) disable iff (!rst_n)
      (bus_wr && bus_port && idx_q == IX_CTL && !ctl_q[CTL_EN_BIT] && bus_wdata[CTL_EN_BIT])
      |=> !stat_q[CTL_EN_BIT]); // R3
   AST_STAT_RO: assert property (@(posedge clk) disable iff (!rst_n)
      (bus_wr && bus_port && idx_q == IX_STAT) |=> $stable(stat_q)); // R3
   AST_PWR_FORCED: assert property (@(posedge clk) disable iff (!rst_n)
      (pwr_q & M_PWR_SET) == M_PWR_SET); // R4
   AST_IRQ_RISE: assert property (@(posedge clk) disable iff (!rst_n)
      (bus_wr && bus_port && idx_q == IX_EERR && (bus_wdata & M_EERR) != '0) |=> ecc_irq); // R9
   AST_IRQ_FALL: assert property (@(posedge clk) disable iff (!rst_n)
      (bus_wr && bus_port && idx_q == IX_EERR && (bus_wdata & M_EERR) == '0) |=> !ecc_irq); // R9
endmodule

bind memctl_cfg_regs memctl_cfg_regs_chk #(.NUM_BANKS(NUM_BANKS)) u_chk (
   .clk       (clk),
   .rst_n     (rst_n),
   .bus_wr    (bus_wr),
   .bus_port  (bus_port),
   .bus_wdata (bus_wdata),
   .idx_q     (idx_q),
   .ctl_q     (ctl_q),
   .stat_q    (stat_q),
   .pwr_q     (pwr_q),
   .probe_hit (probe_hit),
   .probe_sel (probe_sel),
   .ecc_irq   (ecc_irq)
);

// File: tb/memctl_cfg_regs_tb.sv
module memctl_cfg_regs_tb;
   typedef logic [31:0] w_t;

   logic       clk = 1'b0;
   logic       rst_n = 1'b0;
   logic       bus_wr = 1'b0;
   logic       bus_port = 1'b0;
   w_t         bus_wdata = '0;
   w_t         bus_rdata;
   w_t         probe_addr = '0;
   logic       probe_hit;
   logic [3:0] probe_sel;
   logic       ecc_irq;

   int n_chk = 0;
   int n_fail = 0;

   // bench model of the register state
   w_t m_idx, m_ctl, m_st, m_e0, m_e1, m_ea, m_rf, m_pm, m_ec, m_ee;
   w_t m_bk [4];

   always #10 clk = ~clk;

   memctl_cfg_regs #(.NUM_BANKS(4), .SIZE_UNIT_LOG2(22)) u_dut (
      .clk(clk), .rst_n(rst_n), .bus_wr(bus_wr), .bus_port(bus_port),
      .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .probe_addr(probe_addr),
      .probe_hit(probe_hit), .probe_sel(probe_sel), .ecc_irq(ecc_irq)
   );

   task automatic chk(bit ok, string req, w_t act, w_t exp);
      n_chk++;
      if (!ok) begin
         n_fail++;
         $display("FAIL %s actual=%08h expected=%08h", req, act, exp);
      end
   endtask

   task automatic mdl_reset();
      m_idx = '0; m_ctl = 32'h0080_0000; m_st = '0; m_e0 = '0; m_e1 = '0; m_ea = '0;
      m_rf = 32'h05F0_0000; m_pm = 32'h07C0_0000; m_ec = '0; m_ee = '0;
      for (int b = 0; b < 4; b++) m_bk[b] = '0;
   endtask

   task automatic mdl_data_write(w_t d);
      w_t nv;
      case (m_idx)
         32'h00: m_e0 = m_e0 & ~d;
         32'h08: m_e1 = m_e1 & ~d;
         32'h10: m_ea = d;
         32'h20: begin
            nv = d & 32'hFFE0_0000;
            if (!m_ctl[31] && nv[31]) m_st[31] = 1'b0;
            else if (m_ctl[31] && !nv[31]) m_st[31] = 1'b1;
            if (!m_ctl[30] && nv[30]) m_st[30] = 1'b1;
            else if (m_ctl[30] && !nv[30]) m_st[30] = 1'b0;
            m_ctl = nv;
         end
         32'h30: m_rf = d & 32'h3FF8_0000;
         32'h34: m_pm = (d & 32'hF800_0000) | 32'h07C0_0000;
         32'h40, 32'h44, 32'h48, 32'h4C: m_bk[m_idx[3:2]] = d & 32'hFFDE_E001;
         32'h94: m_ec = d & 32'h00F0_0000;
         32'h98: m_ee = d & 32'hFFF0_F000;
         default: ;
      endcase
   endtask

   function automatic w_t exp_rd(w_t ix);
      case (ix)
         32'h00: return m_e0;
         32'h08: return m_e1;
         32'h10: return m_ea;
         32'h20: return m_ctl;
         32'h24: return m_st;
         32'h30: return m_rf;
         32'h34: return m_pm;
         32'h40, 32'h44, 32'h48, 32'h4C: return m_bk[ix[3:2]];
         32'h94: return m_ec;
         32'h98: return m_ee;
         default: return 32'hFFFF_FFFF;
      endcase
   endfunction

   function automatic logic [3:0] exp_sel(w_t a);
      for (int b = 0; b < 4; b++) begin
         logic [2:0] code;
         w_t sz;
         code = m_bk[b][19:17];
         if (m_ctl[31] && m_bk[b][0] && code != 3'd7) begin
            sz = 32'h0040_0000 << code;
            if ((a & ~(sz - 32'd1)) == (m_bk[b] & 32'hFF80_0000)) return 4'b0001 << b;
         end
      end
      return 4'b0000;
   endfunction

   task automatic bus_write(bit port, w_t d);
      @(negedge clk);
      bus_wr = 1'b1; bus_port = port; bus_wdata = d;
      @(negedge clk);
      bus_wr = 1'b0;
      if (!port) m_idx = d;
      else mdl_data_write(d);
   endtask

   task automatic rd_check(w_t ix, string req);
      bus_write(1'b0, ix);
      bus_port = 1'b1;
      #1;
      chk(bus_rdata == exp_rd(ix), req, bus_rdata, exp_rd(ix));
   endtask

   task automatic probe_check(w_t a, string req);
      @(negedge clk);
      probe_addr = a;
      #1;
      chk(probe_sel == exp_sel(a) && probe_hit == (exp_sel(a) != 0), req,
          {27'd0, probe_hit, probe_sel}, {27'd0, exp_sel(a) != 0, exp_sel(a)});
   endtask

   w_t known_ix [15] = '{32'h00, 32'h08, 32'h10, 32'h20, 32'h24, 32'h30, 32'h34, 32'h40,
                         32'h44, 32'h48, 32'h4C, 32'h80, 32'h94, 32'h98, 32'h5C};

   task automatic check_all(string req);
      for (int i = 0; i < 15; i++) rd_check(known_ix[i], req);
   endtask

   initial begin
      repeat (200000) @(posedge clk);
      n_chk++; n_fail++;
      $display("FAIL R1 watchdog actual=running expected=finished");
      $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
      $finish;
   end

   initial begin
      void'($urandom(32'd20240611));
      mdl_reset();
      repeat (3) @(negedge clk);
      rst_n = 1'b1;

      // R2 reset state
      #1;
      chk(bus_rdata == 32'h0, "R1 R2 index after reset", bus_rdata, 32'h0);
      chk({31'd0, ecc_irq} == 32'h0, "R2 irq after reset", {31'd0, ecc_irq}, 32'h0);
      check_all("R2 reset value");
      probe_check(32'h0000_0000, "R2 no bank mapped");

      // R1 index readback
      bus_write(1'b0, 32'hDEAD_BEEF);
      bus_port = 1'b0; #1;
      chk(bus_rdata == 32'hDEAD_BEEF, "R1 index readback", bus_rdata, 32'hDEAD_BEEF);

      // R4 field masks
      bus_write(1'b0, 32'h30); bus_write(1'b1, 32'hFFFF_FFFF); rd_check(32'h30, "R4 refresh mask");
      bus_write(1'b0, 32'h34); bus_write(1'b1, 32'h0000_0000); rd_check(32'h34, "R4 pm forced bits");
      bus_write(1'b0, 32'h34); bus_write(1'b1, 32'hFFFF_FFFF); rd_check(32'h34, "R4 pm keep bits");
      bus_write(1'b0, 32'h94); bus_write(1'b1, 32'hFFFF_FFFF); rd_check(32'h94, "R4 ecc cfg mask");
      bus_write(1'b0, 32'h10); bus_write(1'b1, 32'h1234_5679); rd_check(32'h10, "R4 error address");

      // R5 write-one-to-clear never sets
      bus_write(1'b0, 32'h00); bus_write(1'b1, 32'hFFFF_FFFF); rd_check(32'h00, "R5 err0 w1c");
      bus_write(1'b0, 32'h08); bus_write(1'b1, 32'h0000_0000); rd_check(32'h08, "R5 err1 w1c");

      // R3 control and status
      bus_write(1'b0, 32'h24); bus_write(1'b1, 32'hFFFF_FFFF); rd_check(32'h24, "R3 status read-only");
      bus_write(1'b0, 32'h20); bus_write(1'b1, 32'hFFFF_FFFF);
      rd_check(32'h20, "R3 control mask");
      rd_check(32'h24, "R3 status after enable rise");
      chk(m_st == 32'h4000_0000, "R3 model status rise", m_st, 32'h4000_0000);
      bus_write(1'b0, 32'h20); bus_write(1'b1, 32'h0000_0000);
      rd_check(32'h24, "R3 status after enable fall");
      chk(m_st == 32'h8000_0000, "R3 model status fall", m_st, 32'h8000_0000);

      // R10 undefined and timing indices
      rd_check(32'h80, "R10 timing reads ones");
      rd_check(32'h84, "R10 undefined reads ones");
      bus_write(1'b0, 32'h50); bus_write(1'b1, 32'h0000_0000);
      bus_write(1'b0, 32'h80); bus_write(1'b1, 32'h0000_0000);
      check_all("R10 undefined write no effect");

      // R6 R7 R8 directed bank decode
      bus_write(1'b0, 32'h40); bus_write(1'b1, 32'h0000_0000 | (32'd2 << 17) | 32'h0000_FFFF); // 16 MiB at 0
      bus_write(1'b0, 32'h44); bus_write(1'b1, 32'h0100_0000 | (32'd0 << 17) | 32'd1);         // 4 MiB
      bus_write(1'b0, 32'h48); bus_write(1'b1, 32'h0000_0000 | (32'd3 << 17) | 32'd1);         // 32 MiB
      bus_write(1'b0, 32'h4C); bus_write(1'b1, 32'h0400_0000 | (32'd7 << 17) | 32'd1);         // reserved
      rd_check(32'h40, "R6 bank0 stored mask");
      rd_check(32'h4C, "R6 bank3 stored mask");
      probe_check(32'h0010_0000, "R7 controller disabled no hit");
      bus_write(1'b0, 32'h20); bus_write(1'b1, 32'h8000_0000);
      probe_check(32'h0010_0000, "R8 overlap lowest wins");
      probe_check(32'h0100_0004, "R8 bank1 over bank2");
      probe_check(32'h0180_0000, "R7 only bank2");
      probe_check(32'h0400_0000, "R7 reserved size code");
      probe_check(32'h0200_0000, "R7 miss above all banks");
      probe_check(32'h0140_0000, "R7 just past bank1");

      // R9 interrupt
      bus_write(1'b0, 32'h98); bus_write(1'b1, 32'h000F_0FFF);
      chk({31'd0, ecc_irq} == 32'h0, "R9 masked-out bits no irq", {31'd0, ecc_irq}, 32'h0);
      bus_write(1'b1, 32'h0000_1000);
      chk({31'd0, ecc_irq} == 32'h1, "R9 irq rises", {31'd0, ecc_irq}, 32'h1);
      rd_check(32'h98, "R9 ecc status mask");
      bus_write(1'b0, 32'h98); bus_write(1'b1, 32'h0000_0000);
      chk({31'd0, ecc_irq} == 32'h0, "R9 irq falls", {31'd0, ecc_irq}, 32'h0);

      // random mix
      for (int it = 0; it < 400; it++) begin
         w_t ix, d, a;
         ix = known_ix[$urandom_range(14, 0)];
         d = $urandom();
         if (ix == 32'h20 && ($urandom_range(3, 0) != 0)) d[31] = 1'b1;
         bus_write(1'b0, ix);
         bus_write(1'b1, d);
         chk({31'd0, ecc_irq} == {31'd0, m_ee != 0}, "R9 random irq", {31'd0, ecc_irq}, {31'd0, m_ee != 0});
         rd_check(known_ix[$urandom_range(14, 0)], "R1 R4 R6 random readback");
         a = (m_bk[$urandom_range(3, 0)] & 32'hFF80_0000) | ($urandom() & 32'h03FF_FFFF);
         probe_check(a, "R7 R8 random probe");
      end

      $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
      $finish;
   end
endmodule